// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block keeps the 8-bit status byte of a serial non-volatile memory and decides, cycle by cycle, two things: whether a data write to the address now presented may proceed, and whether a status-byte write may proceed. It sits beside the command decoder of the serial front end. The decoder turns recognised commands into single-cycle pulses: latch set, latch clear and status write with its byte. It also reports the start of each transaction, so that the level of the external write-protect pin can be captured there.

Write permission rests on three things together: a volatile write-enable latch, a sticky lock bit in the status byte and the captured pin level. Data-write permission also depends on a two-bit span field, which fences off nothing, the top quarter, the top half or the whole of the address space. The bits that model non-volatile cells are cleared only by the power-on reset. The soft reset clears only the volatile latch and the captured pin level.

Top module: `srwp_unit`

## Requirements
- R1: While `por_n` is low, and in the cycle after it is released, `status_o` reads 0x00 and both `mem_wr_ok` and `sts_wr_ok` are 0.
- R2: A cycle with `rst_n` low (and `por_n` high) clears status bit 1 (the write-enable latch) and leaves bits 7:2 and bit 0 unchanged. It also resets the captured pin level to low.
- R3: A `wen_set` pulse makes status bit 1 read 1 from the next cycle. A `wen_clr` pulse makes it read 0. When both arrive in the same cycle, the clear wins.
- R4: While status bit 1 is 0, `mem_wr_ok` and `sts_wr_ok` are both 0, whatever the other bits, the address and the pin.
- R5: While bit 1 is 1 and bit 7 (the lock bit) is 0, `sts_wr_ok` is 1, whatever the level of the write-protect pin.
- R6: While bits 1 and 7 are both 1, `sts_wr_ok` equals the level of `wp_pin` sampled in the last cycle with `cs_fall` high. A pin change without `cs_fall` has no effect.
- R7: A `sts_wr_req` pulse while `sts_wr_ok` is 1 loads bits 7:2 and bit 0 from `sts_wr_data` in the next cycle. Bit 1 keeps its value.
- R8: A `sts_wr_req` pulse while `sts_wr_ok` is 0 leaves all eight status bits unchanged.
- R9: With bit 1 set, status bits 3:2 select the span. 00 fences nothing. 01 fences addresses whose top two bits are 11 (0x18000 to 0x1FFFF at 17 bits). 10 fences addresses whose top bit is 1 (0x10000 to 0x1FFFF). 11 fences every address. `mem_wr_ok` is 1 exactly for addresses outside the fence.
- R10: Status bits 6, 5, 4 and 0 can be written and read back, and they have no effect on `mem_wr_ok` or `sts_wr_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset; clears every bit |
| rst_n | input | 1 | Synchronous active-low soft reset; clears volatile state only |
| wen_set | input | 1 | One-cycle pulse: set the write-enable latch |
| wen_clr | input | 1 | One-cycle pulse: clear the write-enable latch |
| sts_wr_req | input | 1 | One-cycle pulse: request a status-byte write |
| sts_wr_data | input | 8 | Byte offered with the status write |
| wp_pin | input | 1 | External write-protect pin level (high = writes allowed) |
| cs_fall | input | 1 | Pulse marking the start of a transaction; captures `wp_pin` |
| addr | input | ADDR_W | Target address of a pending data write |
| status_o | output | 8 | Current status byte for readback |
| mem_wr_ok | output | 1 | Data write to `addr` is permitted |
| sts_wr_ok | output | 1 | Status-byte write is permitted |

## Verification
The bench builds the unit with the default 17-bit address. At that width the fence edges fall at concrete addresses: 0x17FFF against 0x18000 for the quarter, and 0x0FFFF against 0x10000 for the half, together with the extremes 0x00000 and 0x1FFFF. Each edge is probed from both sides under each span code. The pin is toggled both with and without a transaction start, so the capture rule can be told apart from a live pin. The two resets are exercised after the lock and span bits hold non-zero values, so the retained bits can be told apart from the cleared latch.

// File: rtl/srwp_pkg.sv
// Package: shared types and bit positions for the status write-protection unit.
// Assumes an 8-bit status byte whose lock, span and latch bits sit at fixed
// positions that the command decoder and readback path also rely on.
package srwp_pkg;

    localparam int STS_W      = 8;
    localparam int POS_LOCK   = 7;
    localparam int POS_SPAN_H = 3;
    localparam int POS_SPAN_L = 2;
    localparam int POS_WEL    = 1;

    // Span of the fenced region at the top of the address space.
    typedef enum logic [1:0] {
        SPAN_NONE    = 2'b00,
        SPAN_QUARTER = 2'b01,
        SPAN_HALF    = 2'b10,
        SPAN_ALL     = 2'b11
    } span_e;

    // Field view of the status byte, MSB first.
    typedef struct packed {
        logic       lock;
        logic [2:0] spare_hi;
        span_e      span;
        logic       wel;
        logic       spare_lo;
    } status_t;

endpackage

// File: rtl/srwp_wel_latch.sv
// Module: write-enable latch.
// Holds the volatile enable bit. Set and clear arrive as single-cycle pulses;
// clear has priority. Both resets clear the bit.
module srwp_wel_latch (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);

    logic wel_q;

    // Update the latch: resets, then clear, then set.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            wel_q <= 1'b0;
        end else if (clr_i) begin
            wel_q <= 1'b0;
        end else if (set_i) begin
            wel_q <= 1'b1;
        end
    end

    assign wel_o = wel_q;

endmodule

// File: rtl/srwp_nv_store.sv
// Module: retained status bits.
// Models the non-volatile cells of the status byte: every bit except the
// write-enable position. Only the power-on reset clears them. The write enable
// must already carry the permission decision. The enable-latch position reads
// as zero here; the top merges the live latch in.
module srwp_nv_store #(
    parameter int WIDTH    = 8,
    parameter int SKIP_POS = 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] bits_o
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        if (gi == SKIP_POS) begin : g_hole
            // The enable-latch position is not stored here.
            assign bits_o[gi] = 1'b0;
        end else begin : g_cell
            logic cell_q;
            // One retained cell: cleared by power-on only, loaded on accepted writes.
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    cell_q <= 1'b0;
                end else if (wr_en_i) begin
                    cell_q <= wr_data_i[gi];
                end
            end
            assign bits_o[gi] = cell_q;
        end
    end

endmodule

// File: rtl/srwp_wp_sample.sv
// Module: write-protect pin capture.
// Samples the external pin level only at the start of a transaction, so a
// pin change in the middle of a transaction is not seen until the next one.
// It resets to low, the protective level.
module srwp_wp_sample (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic cs_fall_i,
    input  logic wp_pin_i,
    output logic wp_o
);

    logic wp_q;

    // Capture the pin at each transaction start.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            wp_q <= 1'b0;
        end else if (cs_fall_i) begin
            wp_q <= wp_pin_i;
        end
    end

    assign wp_o = wp_q;

endmodule

// File: rtl/srwp_region_decode.sv
// Module: fenced-region decoder.
// Flags an address that falls inside the fence chosen by the span code.
// Quarter and half fences are aligned to the top of the address space, so
// only the top one or two address bits are compared. Purely combinational.
module srwp_region_decode
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  span_e             span_i,
    output logic              fenced_o
);

    localparam int TOP = ADDR_W - 1;

    logic in_top_half;
    logic in_top_quarter;

    assign in_top_half    = addr_i[TOP];
    assign in_top_quarter = addr_i[TOP] & addr_i[TOP-1];

    // Select the fence test for the current span code.
    always_comb begin
        unique case (span_i)
            SPAN_NONE:    fenced_o = 1'b0;
            SPAN_QUARTER: fenced_o = in_top_quarter;
            SPAN_HALF:    fenced_o = in_top_half;
            SPAN_ALL:     fenced_o = 1'b1;
            default:      fenced_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/srwp_unit.sv
// Module: status register write-protection unit (top).
// Combines the enable latch, the retained status bits, the captured pin level
// and the region decoder into readback and the two permission flags. Assumes
// command pulses are one cycle wide and already decoded. A status write is
// judged on the state before the edge, so it takes effect in the next cycle.
module srwp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wen_set,
    input  logic              wen_clr,
    input  logic              sts_wr_req,
    input  logic [STS_W-1:0]  sts_wr_data,
    input  logic              wp_pin,
    input  logic              cs_fall,
    input  logic [ADDR_W-1:0] addr,
    output logic [STS_W-1:0]  status_o,
    output logic              mem_wr_ok,
    output logic              sts_wr_ok
);

    logic             wel;
    logic             wp_s;
    logic             fenced;
    logic             sts_commit;
    logic [STS_W-1:0] nv_bits;
    status_t          sts_view;

    srwp_wel_latch u_wel (
        .clk   (clk),
        .por_n (por_n),
        .rst_n (rst_n),
        .set_i (wen_set),
        .clr_i (wen_clr),
        .wel_o (wel)
    );

    srwp_wp_sample u_wp (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cs_fall_i (cs_fall),
        .wp_pin_i  (wp_pin),
        .wp_o      (wp_s)
    );

    srwp_nv_store #(
        .WIDTH    (STS_W),
        .SKIP_POS (POS_WEL)
    ) u_nv (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en_i   (sts_commit),
        .wr_data_i (sts_wr_data),
        .bits_o    (nv_bits)
    );

    // Merge the retained bits with the live enable latch into the readback byte.
    always_comb begin
        status_o          = nv_bits;
        status_o[POS_WEL] = wel;
        sts_view          = status_t'(status_o);
    end

    srwp_region_decode #(
        .ADDR_W (ADDR_W)
    ) u_region (
        .addr_i   (addr),
        .span_i   (sts_view.span),
        .fenced_o (fenced)
    );

    // Status byte is writable with the latch set and either unlocked or pin high.
    assign sts_wr_ok  = wel & (~sts_view.lock | wp_s);
    // An accepted write commits unless a soft reset is active this cycle.
    assign sts_commit = sts_wr_req & sts_wr_ok & rst_n;
    // A data write needs the latch and an address outside the fence.
    assign mem_wr_ok  = wel & ~fenced;

endmodule

// File: rtl/srwp_unit_chk.sv
// Module: property checker for srwp_unit, attached through bind.
// Observes only the ports of the unit.
module srwp_unit_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              wen_set,
    input logic              wen_clr,
    input logic              sts_wr_req,
    input logic [7:0]        sts_wr_data,
    input logic              cs_fall,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        status_o,
    input logic              mem_wr_ok,
    input logic              sts_wr_ok
);

    AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> !status_o[1] && (status_o[7:2] == $past(status_o[7:2])) && (status_o[0] == $past(status_o[0]))); // R2

    AST_WEL_RISE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wen_set && !wen_clr |=> status_o[1]); // R3

    AST_WEL_DROP: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wen_clr |=> !status_o[1]); // R3

    AST_NO_LATCH_LOCK: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !status_o[1] |-> !mem_wr_ok && !sts_wr_ok); // R4

    AST_UNLOCKED_OPEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        status_o[1] && !status_o[7] |-> sts_wr_ok); // R5

    AST_PIN_HELD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        status_o[1] && status_o[7] && !cs_fall && !wen_set && !wen_clr && !sts_wr_req |=> $stable(sts_wr_ok)); // R6

    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sts_wr_req && sts_wr_ok && !wen_set && !wen_clr
        |=> (status_o[7:2] == $past(sts_wr_data[7:2])) && (status_o[0] == $past(sts_wr_data[0])) && status_o[1]); // R7

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sts_wr_req && !sts_wr_ok && !wen_set && !wen_clr |=> $stable(status_o)); // R8

    AST_ALL_FENCED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        status_o[3:2] == 2'b11 |-> !mem_wr_ok); // R9

    AST_OPEN_SPAN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        status_o[1] && status_o[3:2] == 2'b00 |-> mem_wr_ok); // R9

endmodule

bind srwp_unit srwp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .wen_set     (wen_set),
    .wen_clr     (wen_clr),
    .sts_wr_req  (sts_wr_req),
    .sts_wr_data (sts_wr_data),
    .cs_fall     (cs_fall),
    .addr        (addr),
    .status_o    (status_o),
    .mem_wr_ok   (mem_wr_ok),
    .sts_wr_ok   (sts_wr_ok)
);

// File: tb/sim_srwp_unit.sv
`timescale 1ns/1ps
module sim_srwp_unit;

    localparam int AW = 17;

    typedef struct packed {
        logic          set;
        logic          clr;
        logic          swr;
        logic [7:0]    swd;
        logic          wp;
        logic          csf;
        logic [AW-1:0] adr;
        logic [7:0]    est;
        logic          em;
        logic          es;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 19;
    // set clr swr data wp csf addr | status mem sts | requirement
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,17'h00000, 8'h00,1'b0,1'b0,4'd4},  // R4 idle, latch clear
        '{1'b0,1'b0,1'b1,8'hFF,1'b0,1'b0,17'h00000, 8'h00,1'b0,1'b0,4'd8},  // R8 rejected without latch
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,17'h00000, 8'h02,1'b1,1'b1,4'd3},  // R3 set latch
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,17'h00000, 8'h02,1'b1,1'b1,4'd5},  // R5 pin low, unlocked
        '{1'b0,1'b0,1'b1,8'h84,1'b0,1'b0,17'h18000, 8'h86,1'b0,1'b0,4'd7},  // R7 lock + quarter
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,17'h17FFF, 8'h86,1'b1,1'b0,4'd9},  // R9 below quarter edge
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,17'h17FFF, 8'h86,1'b1,1'b0,4'd6},  // R6 pin high, no start
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,17'h1FFFF, 8'h86,1'b0,1'b1,4'd6},  // R6 captured at start
        '{1'b0,1'b0,1'b1,8'h89,1'b1,1'b0,17'h10000, 8'h8B,1'b0,1'b1,4'd9},  // R9 half span edge
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,17'h0FFFF, 8'h8B,1'b1,1'b1,4'd9},  // R9 below half edge
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,17'h0FFFF, 8'h8B,1'b1,1'b0,4'd6},  // R6 low captured
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,17'h0FFFF, 8'h8B,1'b1,1'b0,4'd8},  // R8 locked, rejected
        '{1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,17'h00000, 8'h89,1'b0,1'b0,4'd3},  // R3 clear wins
        '{1'b0,1'b0,1'b1,8'h70,1'b0,1'b0,17'h00000, 8'h89,1'b0,1'b0,4'd8},  // R8 no latch
        '{1'b1,1'b0,1'b0,8'h00,1'b1,1'b1,17'h00000, 8'h8B,1'b1,1'b1,4'd6},  // R6 set + start high
        '{1'b0,1'b0,1'b1,8'h0C,1'b1,1'b0,17'h00000, 8'h0E,1'b0,1'b1,4'd9},  // R9 all fenced, R7 bit1 kept
        '{1'b0,1'b0,1'b1,8'h70,1'b1,1'b0,17'h1FFFF, 8'h72,1'b1,1'b1,4'd10}, // R10 spare bits set
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,17'h1FFFF, 8'h72,1'b1,1'b1,4'd5},  // R5 unlocked, pin low
        '{1'b0,1'b1,1'b0,8'h00,1'b0,1'b0,17'h1FFFF, 8'h70,1'b0,1'b0,4'd4}   // R4 cleared latch
    };

    logic          clk = 1'b0;
    logic          por_n, rst_n, wen_set, wen_clr, sts_wr_req, wp_pin, cs_fall;
    logic [7:0]    sts_wr_data;
    logic [AW-1:0] addr;
    logic [7:0]    status_o;
    logic          mem_wr_ok, sts_wr_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    srwp_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .wen_set(wen_set), .wen_clr(wen_clr),
        .sts_wr_req(sts_wr_req), .sts_wr_data(sts_wr_data),
        .wp_pin(wp_pin), .cs_fall(cs_fall), .addr(addr),
        .status_o(status_o), .mem_wr_ok(mem_wr_ok), .sts_wr_ok(sts_wr_ok)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [7:0] st, input logic m, input logic s);
        chk(req, "status", status_o, st);
        chk(req, "mem_wr_ok", {7'd0, mem_wr_ok}, {7'd0, m});
        chk(req, "sts_wr_ok", {7'd0, sts_wr_ok}, {7'd0, s});
    endtask

    task automatic idle_inputs();
        wen_set = 0; wen_clr = 0; sts_wr_req = 0; sts_wr_data = 0; cs_fall = 0;
    endtask

    // Apply one cycle of stimulus at a falling edge; results are sampled at the next one.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        por_n = 0; rst_n = 0; wp_pin = 0; addr = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        chk_all("R1", 8'h00, 1'b0, 1'b0);
        por_n = 1; rst_n = 1;
        @(negedge clk);
        chk_all("R1", 8'h00, 1'b0, 1'b0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            wen_set = VEC[i].set; wen_clr = VEC[i].clr; sts_wr_req = VEC[i].swr;
            sts_wr_data = VEC[i].swd; wp_pin = VEC[i].wp; cs_fall = VEC[i].csf;
            addr = VEC[i].adr;
            step();
            chk_all($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].est, VEC[i].em, VEC[i].es);
        end

        // R10: bit 0 alone changes no permission (status 0x70 -> latch -> write 0x01).
        wen_set = 1; step();
        chk_all("R10", 8'h72, 1'b1, 1'b1);
        sts_wr_req = 1; sts_wr_data = 8'h01; addr = 17'h1FFFF; step();
        chk_all("R10", 8'h03, 1'b1, 1'b1);

        // R2: lock on, capture pin high, then soft reset keeps retained bits.
        sts_wr_req = 1; sts_wr_data = 8'hA5; step();   // lock, quarter, spares
        chk_all("R7", 8'hA7, 1'b0, 1'b0);               // pin captured low earlier
        wp_pin = 1; cs_fall = 1; addr = 17'h00000; step();
        chk_all("R6", 8'hA7, 1'b1, 1'b1);
        rst_n = 0; step();
        rst_n = 1;
        chk_all("R2", 8'hA5, 1'b0, 1'b0);
        wen_set = 1; step();
        chk_all("R2", 8'hA7, 1'b1, 1'b0);               // pin capture reset low

        // R1: power-on reset clears retained bits too.
        por_n = 0; step();
        por_n = 1;
        chk_all("R1", 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule